// File: doc/BRIEF.md
# Two-Stage Candidate Confirmation Filter

This block sits in a trigger path that sees, on every bunch crossing, one candidate record from each of eight pads and one 32-bit confirmation vector from an external detector. Each record carries a 3-bit threshold code, a single cross-pad flag and an opaque payload. The filter can require a candidate to be confirmed in two ways, one after the other. The first check compares the candidate against the flags of the other pads. The second check compares it against the external vector. A candidate that fails an enabled check leaves the block with its threshold code forced to zero, and every other bit passes through unchanged.

Whether a check applies depends on the pad and on the threshold code. Each pad has its own enable bit and its own mapping mask for each code it can carry. The enable words and masks are static configuration, loaded through a small write port while the run-enable input is low. Each check is registered once, so results appear two cycles after the inputs, together with a valid strobe.

Top module: `cand_confirm_filter`

## Requirements
- R1: Pad p occupies in_rec[p*10 +: 10]. Within a record, bits [2:0] hold the threshold code, bit 3 holds the cross-pad flag and bits [9:4] hold the payload. Codes 1 to 3 form the low class and codes 4 to 6 form the high class. Codes 0 and 7 are never altered.
- R2: Stage one acts on low-class codes. It applies when bit (4*p + code) of the stage-one enable word is set. The stage builds an 8-bit vector whose bit i is the flag of pad i and ANDs it with the stage-one mask for pad p, slot code-1. A zero result clears the code.
- R3: Stage two acts on codes 1 to 6. The enable bit at position (4*p + code) comes from the low enable word for codes 1 to 3 and from the high enable word for codes 4 to 6. Positions above 31 (pad 7 with codes 4 to 6) read as disabled. When stage two is enabled, in_conf is ANDed with the stage-two mask for pad p, slot code-1, and a zero result clears the code.
- R4: Stage two sees the code as it leaves stage one. A code cleared by stage one stays zero, even if stage two would confirm the original code.
- R5: Only the threshold code field can change. The flag and payload bits of every pad reach out_rec unchanged.
- R6: out_valid and out_rec show the result for the in_valid, in_rec and in_conf values sampled two rising edges earlier.
- R7: Reset clears out_valid and sets all enable words and masks to zero. With this configuration no code is altered.
- R8: cfg_addr = {kind[7:6], pad[5:3], slot[2:0]}. Kind 0 selects an enable word: slot 0 is stage one, slot 1 is stage-two low and slot 2 is stage-two high. Kind 1 selects the stage-one mask for slot 0 to 2, taking cfg_wdata[7:0]. Kind 2 selects the stage-two mask for slot 0 to 5. All other kind and slot values are ignored.
- R9: A write with cfg_we high is ignored while run_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High while running; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address {kind, pad, slot} |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input crossing valid |
| in_rec | input | 80 | Eight pad records, 10 bits each |
| in_conf | input | 32 | External confirmation vector for this crossing |
| out_valid | output | 1 | Output crossing valid |
| out_rec | output | 80 | Filtered pad records |

## Verification
The bench aims at the enable-bit indexing. Pad 7 with high codes must read as disabled, because a decoder that wraps or extends the index would wrongly clear those codes. A directed case sets up a candidate that fails stage one but passes stage two. A design that rechecks the original code in stage two would let that candidate through. Further cases write to unused slot and kind addresses, and write while run_en is high. A sloppy decoder would then silently start clearing codes that should pass. Random configuration and sparse confirmation vectors test mask-slot selection (an off-by-one on code-1 or on the pad stride). They also catch any change to flag or payload bits.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    // Threshold code width and class limits
    localparam int CODE_W = 3;
    localparam int N_LOW  = 3;
    localparam int N_ALL  = 6;

    // Enable-word stride per pad; one slot per code value
    localparam int SLOT_W = 4;

    // Configuration address fields
    localparam int KIND_W = 2;
    localparam int IDX_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        CFG_ENABLE = 2'd0,
        CFG_XMASK  = 2'd1,
        CFG_EMASK  = 2'd2,
        CFG_SPARE  = 2'd3
    } cfg_kind_e;

    localparam int SEL_XEN  = 0;
    localparam int SEL_LOEN = 1;
    localparam int SEL_HIEN = 2;

    function automatic logic is_low(input logic [CODE_W-1:0] c);
        return (c != '0) && (c <= CODE_W'(N_LOW));
    endfunction

    function automatic logic is_any(input logic [CODE_W-1:0] c);
        return (c != '0) && (c <= CODE_W'(N_ALL));
    endfunction

endpackage

// File: rtl/ccf_cfg_regs.sv
module ccf_cfg_regs
    import ccf_pkg::*;
#(
    parameter int NPAD  = 8,
    parameter int EXT_W = 32,
    localparam int EN_W   = NPAD * SLOT_W,
    localparam int CFG_W  = (EXT_W > EN_W) ? EXT_W : EN_W,
    localparam int PAD_AW = (NPAD > 1) ? $clog2(NPAD) : 1,
    localparam int ADDR_W = KIND_W + PAD_AW + IDX_W,
    localparam int XM_W   = NPAD * N_LOW * NPAD,
    localparam int EM_W   = NPAD * N_ALL * EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [EN_W-1:0]   xen_o,
    output logic [EN_W-1:0]   loen_o,
    output logic [EN_W-1:0]   hien_o,
    output logic [XM_W-1:0]   xmask_o,
    output logic [EM_W-1:0]   emask_o
);

    typedef struct packed {
        logic [EN_W-1:0] xen;
        logic [EN_W-1:0] loen;
        logic [EN_W-1:0] hien;
        logic [XM_W-1:0] xm;
        logic [EM_W-1:0] em;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        logic [KIND_W-1:0] kind;
        int                pad;
        int                sel;
        cfg_d = cfg_q;
        kind  = addr[ADDR_W-1 -: KIND_W];
        pad   = int'(addr[IDX_W +: PAD_AW]);
        sel   = int'(addr[IDX_W-1:0]);
        if (we && !run_en && pad < NPAD) begin
            case (cfg_kind_e'(kind))
                CFG_ENABLE: begin
                    case (sel)
                        SEL_XEN:  cfg_d.xen  = wdata[EN_W-1:0];
                        SEL_LOEN: cfg_d.loen = wdata[EN_W-1:0];
                        SEL_HIEN: cfg_d.hien = wdata[EN_W-1:0];
                        default:  ;
                    endcase
                end
                CFG_XMASK: begin
                    if (sel < N_LOW)
                        cfg_d.xm[(pad*N_LOW + sel)*NPAD +: NPAD] = wdata[NPAD-1:0];
                end
                CFG_EMASK: begin
                    if (sel < N_ALL)
                        cfg_d.em[(pad*N_ALL + sel)*EXT_W +: EXT_W] = wdata[EXT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign xen_o   = cfg_q.xen;
    assign loen_o  = cfg_q.loen;
    assign hien_o  = cfg_q.hien;
    assign xmask_o = cfg_q.xm;
    assign emask_o = cfg_q.em;

endmodule

// File: rtl/ccf_xpad_stage.sv
module ccf_xpad_stage
    import ccf_pkg::*;
#(
    parameter int NPAD  = 8,
    parameter int REC_W = 10,
    parameter int EXT_W = 32,
    localparam int BUS_W = NPAD * REC_W,
    localparam int EN_W  = NPAD * SLOT_W,
    localparam int XM_W  = NPAD * N_LOW * NPAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [BUS_W-1:0] rec_i,
    input  logic [EXT_W-1:0] conf_i,
    input  logic [EN_W-1:0]  xen_i,
    input  logic [XM_W-1:0]  xmask_i,
    output logic             valid_o,
    output logic [BUS_W-1:0] rec_o,
    output logic [EXT_W-1:0] conf_o
);

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] rec;
        logic [EXT_W-1:0] conf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NPAD-1:0] flag_vec;
        for (int i = 0; i < NPAD; i++)
            flag_vec[i] = rec_i[i*REC_W + CODE_W];

        st_d.valid = valid_i;
        st_d.rec   = rec_i;
        st_d.conf  = conf_i;

        for (int p = 0; p < NPAD; p++) begin
            logic [CODE_W-1:0] code;
            logic              en_bit;
            int                mi;
            code   = rec_i[p*REC_W +: CODE_W];
            en_bit = 1'b0;
            mi     = 0;
            if (is_low(code)) begin
                en_bit = xen_i[p*SLOT_W + int'(code)];
                mi     = (p*N_LOW + int'(code) - 1) * NPAD;
            end
            if (en_bit && ((flag_vec & xmask_i[mi +: NPAD]) == '0))
                st_d.rec[p*REC_W +: CODE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign rec_o   = st_q.rec;
    assign conf_o  = st_q.conf;

endmodule

// File: rtl/ccf_ext_stage.sv
module ccf_ext_stage
    import ccf_pkg::*;
#(
    parameter int NPAD  = 8,
    parameter int REC_W = 10,
    parameter int EXT_W = 32,
    localparam int BUS_W = NPAD * REC_W,
    localparam int EN_W  = NPAD * SLOT_W,
    localparam int EX_W  = EN_W + SLOT_W,
    localparam int EM_W  = NPAD * N_ALL * EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [BUS_W-1:0] rec_i,
    input  logic [EXT_W-1:0] conf_i,
    input  logic [EN_W-1:0]  loen_i,
    input  logic [EN_W-1:0]  hien_i,
    input  logic [EM_W-1:0]  emask_i,
    output logic             valid_o,
    output logic [BUS_W-1:0] rec_o
);

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] rec;
    } st_t;

    st_t st_d, st_q;

    // Zero-extended enable words: slots past the top read as disabled
    logic [EX_W-1:0] lo_ext, hi_ext;
    assign lo_ext = {{SLOT_W{1'b0}}, loen_i};
    assign hi_ext = {{SLOT_W{1'b0}}, hien_i};

    always_comb begin
        st_d.valid = valid_i;
        st_d.rec   = rec_i;
        for (int p = 0; p < NPAD; p++) begin
            logic [CODE_W-1:0] code;
            logic              en_bit;
            int                bi;
            int                mi;
            code   = rec_i[p*REC_W +: CODE_W];
            en_bit = 1'b0;
            bi     = 0;
            mi     = 0;
            if (is_any(code)) begin
                bi     = p*SLOT_W + int'(code);
                en_bit = is_low(code) ? lo_ext[bi] : hi_ext[bi];
                mi     = (p*N_ALL + int'(code) - 1) * EXT_W;
            end
            if (en_bit && ((conf_i & emask_i[mi +: EXT_W]) == '0))
                st_d.rec[p*REC_W +: CODE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign rec_o   = st_q.rec;

endmodule

// File: rtl/cand_confirm_filter.sv
module cand_confirm_filter
    import ccf_pkg::*;
#(
    parameter int NPAD  = 8,
    parameter int PAY_W = 6,
    parameter int EXT_W = 32,
    localparam int REC_W  = CODE_W + 1 + PAY_W,
    localparam int BUS_W  = NPAD * REC_W,
    localparam int EN_W   = NPAD * SLOT_W,
    localparam int CFG_W  = (EXT_W > EN_W) ? EXT_W : EN_W,
    localparam int PAD_AW = (NPAD > 1) ? $clog2(NPAD) : 1,
    localparam int ADDR_W = KIND_W + PAD_AW + IDX_W,
    localparam int XM_W   = NPAD * N_LOW * NPAD,
    localparam int EM_W   = NPAD * N_ALL * EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [BUS_W-1:0]  in_rec,
    input  logic [EXT_W-1:0]  in_conf,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_rec
);

    logic [EN_W-1:0]  xen, loen, hien;
    logic [XM_W-1:0]  xmask;
    logic [EM_W-1:0]  emask;
    logic             s1_valid;
    logic [BUS_W-1:0] s1_rec;
    logic [EXT_W-1:0] s1_conf;

    ccf_cfg_regs #(.NPAD(NPAD), .EXT_W(EXT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .xen_o   (xen),
        .loen_o  (loen),
        .hien_o  (hien),
        .xmask_o (xmask),
        .emask_o (emask)
    );

    ccf_xpad_stage #(.NPAD(NPAD), .REC_W(REC_W), .EXT_W(EXT_W)) u_xpad (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .rec_i   (in_rec),
        .conf_i  (in_conf),
        .xen_i   (xen),
        .xmask_i (xmask),
        .valid_o (s1_valid),
        .rec_o   (s1_rec),
        .conf_o  (s1_conf)
    );

    ccf_ext_stage #(.NPAD(NPAD), .REC_W(REC_W), .EXT_W(EXT_W)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s1_valid),
        .rec_i   (s1_rec),
        .conf_i  (s1_conf),
        .loen_i  (loen),
        .hien_i  (hien),
        .emask_i (emask),
        .valid_o (out_valid),
        .rec_o   (out_rec)
    );

endmodule

// File: rtl/ccf_checker.sv
module ccf_checker #(
    parameter int NPAD   = 8,
    parameter int REC_W  = 10,
    parameter int CODE_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [NPAD*REC_W-1:0]  in_rec,
    input logic                   out_valid,
    input logic [NPAD*REC_W-1:0]  out_rec
);

    // R6: valid strobe travels two cycles
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R7: nothing valid right after reset
    a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    for (genvar p = 0; p < NPAD; p++) begin : g_pad
        // R5: flag and payload pass through untouched
        a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_rec[p*REC_W+CODE_W +: REC_W-CODE_W]
                          == $past(in_rec[p*REC_W+CODE_W +: REC_W-CODE_W], 2));
        // R2: a code is either kept or cleared, never changed to another value
        a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_rec[p*REC_W +: CODE_W] == '0) ||
                          (out_rec[p*REC_W +: CODE_W] == $past(in_rec[p*REC_W +: CODE_W], 2)));
        // R1: codes outside both classes are never touched
        a_r1_outside_class: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(in_rec[p*REC_W +: CODE_W], 2) == '0 ||
                           $past(in_rec[p*REC_W +: CODE_W], 2) == '1))
            |-> out_rec[p*REC_W +: CODE_W] == $past(in_rec[p*REC_W +: CODE_W], 2));
    end

endmodule

bind cand_confirm_filter ccf_checker #(.NPAD(NPAD), .REC_W(REC_W), .CODE_W(ccf_pkg::CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_rec    (in_rec),
    .out_valid (out_valid),
    .out_rec   (out_rec)
);

// File: tb/sim_cand_confirm_filter.sv
module sim_cand_confirm_filter;

    localparam int NPAD  = 8;
    localparam int PAY_W = 6;
    localparam int REC_W = 3 + 1 + PAY_W;
    localparam int BUS_W = NPAD * REC_W;
    localparam int EXT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             in_valid = 1'b0;
    logic [BUS_W-1:0] in_rec = '0;
    logic [EXT_W-1:0] in_conf = '0;
    logic             out_valid;
    logic [BUS_W-1:0] out_rec;

    cand_confirm_filter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_rec    (in_rec),
        .in_conf   (in_conf),
        .out_valid (out_valid),
        .out_rec   (out_rec)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int force_tag = 0;

    // Reference configuration
    logic [31:0] m_xen, m_lo, m_hi;
    logic [7:0]  m_xm [NPAD][3];
    logic [31:0] m_em [NPAD][6];

    // Model scratch and two-deep expected pipe
    logic [BUS_W-1:0] m_exp;
    int               m_tag [NPAD];
    logic             e1_v, e2_v;
    logic [BUS_W-1:0] e1_r, e2_r;
    int               e1_t [NPAD];
    int               e2_t [NPAD];

    function automatic string tname(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [REC_W-1:0] mk(input int code, input bit flag, input int pay);
        return {PAY_W'(pay), flag, 3'(code)};
    endfunction

    function automatic logic [BUS_W-1:0] rnd_rec();
        logic [BUS_W-1:0] r;
        for (int p = 0; p < NPAD; p++) r[p*REC_W +: REC_W] = REC_W'($urandom);
        return r;
    endfunction

    task automatic clear_model();
        m_xen = '0; m_lo = '0; m_hi = '0;
        for (int p = 0; p < NPAD; p++) begin
            for (int k = 0; k < 3; k++) m_xm[p][k] = '0;
            for (int k = 0; k < 6; k++) m_em[p][k] = '0;
        end
    endtask

    // Expected result computed from R1..R4
    task automatic model(input logic [BUS_W-1:0] rec, input logic [EXT_W-1:0] conf);
        logic [NPAD-1:0] fl;
        for (int i = 0; i < NPAD; i++) fl[i] = rec[i*REC_W + 3];
        m_exp = rec;
        for (int p = 0; p < NPAD; p++) begin
            int c;
            int c1;
            int bi;
            bit en2;
            c  = int'(rec[p*REC_W +: 3]);
            c1 = c;
            m_tag[p] = (c == 0 || c == 7) ? 1 : 3;
            if (c >= 1 && c <= 3) begin
                if (m_xen[p*4 + c] && ((fl & m_xm[p][c-1]) == '0)) begin
                    c1 = 0;
                    m_tag[p] = 2;
                end
            end
            if (c1 >= 1 && c1 <= 6) begin
                bi  = p*4 + c1;
                en2 = 1'b0;
                if (bi < 32) en2 = (c1 <= 3) ? m_lo[bi] : m_hi[bi];
                if (en2 && ((conf & m_em[p][c1-1]) == '0)) c1 = 0;
            end
            m_exp[p*REC_W +: 3] = 3'(c1);
        end
    endtask

    task automatic step(input logic v, input logic [BUS_W-1:0] rec, input logic [EXT_W-1:0] conf);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== e2_v) begin
            n_bad++;
            $display("FAIL R6 out_valid got %b exp %b", out_valid, e2_v);
        end
        if (e2_v) begin
            for (int p = 0; p < NPAD; p++) begin
                n_cmp++;
                if (out_rec[p*REC_W +: REC_W] !== e2_r[p*REC_W +: REC_W]) begin
                    n_bad++;
                    if (out_rec[p*REC_W +: 3] !== e2_r[p*REC_W +: 3])
                        $display("FAIL %s pad %0d got %h exp %h",
                                 tname(force_tag != 0 ? force_tag : e2_t[p]), p,
                                 out_rec[p*REC_W +: REC_W], e2_r[p*REC_W +: REC_W]);
                    else
                        $display("FAIL R5 pad %0d got %h exp %h", p,
                                 out_rec[p*REC_W +: REC_W], e2_r[p*REC_W +: REC_W]);
                end
            end
        end
        e2_v = e1_v;
        e2_r = e1_r;
        e2_t = e1_t;
        model(rec, conf);
        e1_v = v;
        e1_r = m_exp;
        e1_t = m_tag;
        in_valid = v;
        in_rec   = rec;
        in_conf  = conf;
    endtask

    task automatic flush();
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
    endtask

    // R8 address map and R9 write blocking mirrored in the model
    task automatic cfg_write(input int kind, input int pad, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {2'(kind), 3'(pad), 3'(idx)};
        cfg_wdata = d;
        if (!run_en) begin
            case (kind)
                0: begin
                    if (idx == 0) m_xen = d;
                    if (idx == 1) m_lo  = d;
                    if (idx == 2) m_hi  = d;
                end
                1: if (idx < 3) m_xm[pad][idx] = d[7:0];
                2: if (idx < 6) m_em[pad][idx] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; run_en = 1'b0;
        repeat (2) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 out_valid in reset got %b exp 0", out_valid);
        end
        rst_n = 1'b1;
        clear_model();
        e1_v = 1'b0;
        e2_v = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R6 watchdog got hang exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] r;
        void'($urandom(32'd20240611));
        clear_model();
        e1_v = 1'b0;
        e2_v = 1'b0;

        // R7: reset state, then pass-through with empty configuration
        do_reset();
        force_tag = 7;
        for (int i = 0; i < 20; i++) step(1'b1, rnd_rec(), $urandom);
        flush();

        // R2: stage-one cross-pad confirmation, pad 2 code 2 needs pad 4 flag
        do_reset();
        force_tag = 2;
        cfg_write(0, 0, 0, 32'h0000_0400);
        cfg_write(1, 2, 1, 32'h0000_0010);
        r = '0; r[2*REC_W +: REC_W] = mk(2, 1'b0, 5); r[4*REC_W +: REC_W] = mk(1, 1'b1, 0);
        step(1'b1, r, '0);                    // confirmed: pad 2 keeps code 2
        r[4*REC_W +: REC_W] = mk(1, 1'b0, 0);
        step(1'b1, r, '0);                    // unconfirmed: pad 2 cleared
        r[2*REC_W +: REC_W] = mk(3, 1'b0, 9);
        step(1'b1, r, '0);                    // code 3 slot not enabled: kept
        flush();

        // R3: stage-two external confirmation, low and high words
        do_reset();
        force_tag = 3;
        cfg_write(0, 0, 1, 32'h0000_0020);    // pad 1 code 1
        cfg_write(2, 1, 0, 32'h0000_0F00);
        cfg_write(0, 0, 2, 32'h0000_0040);    // pad 0 code 6
        cfg_write(2, 0, 5, 32'h8000_0000);
        r = '0; r[1*REC_W +: REC_W] = mk(1, 1'b0, 3); r[0*REC_W +: REC_W] = mk(6, 1'b1, 7);
        step(1'b1, r, 32'h8000_0100);         // both confirmed
        step(1'b1, r, 32'h0000_0001);         // both cleared
        step(1'b1, r, 32'h0000_0200);         // pad 1 kept, pad 0 cleared
        flush();

        // R3 boundary: pad 7 high codes map above bit 31 and stay disabled
        do_reset();
        force_tag = 3;
        cfg_write(0, 0, 2, 32'hFFFF_FFFF);
        for (int c = 4; c <= 6; c++) begin
            r = '0;
            r[7*REC_W +: REC_W] = mk(c, 1'b0, c);
            r[6*REC_W +: REC_W] = mk(c, 1'b0, c);  // pad 6 is enabled and cleared
            step(1'b1, r, 32'hFFFF_FFFF);
        end
        flush();

        // R4: stage one clears, stage two would confirm; code must stay zero
        do_reset();
        force_tag = 4;
        cfg_write(0, 0, 0, 32'h0000_8000);    // pad 3 code 3, stage one
        cfg_write(1, 3, 2, 32'h0000_0001);    // needs pad 0 flag
        cfg_write(0, 0, 1, 32'h0000_8000);    // pad 3 code 3, stage two
        cfg_write(2, 3, 2, 32'hFFFF_FFFF);
        r = '0; r[3*REC_W +: REC_W] = mk(3, 1'b0, 11);
        step(1'b1, r, 32'hFFFF_FFFF);         // cleared in stage one
        r[0*REC_W +: REC_W] = mk(0, 1'b1, 0);
        step(1'b1, r, 32'hFFFF_FFFF);         // confirmed in both
        flush();

        // R8: writes to unused kinds and slots leave the filter inactive
        do_reset();
        force_tag = 8;
        for (int s = 3; s < 8; s++) cfg_write(0, 0, s, 32'hFFFF_FFFF);
        for (int s = 0; s < 8; s++) cfg_write(3, s, s, 32'hFFFF_FFFF);
        for (int p = 0; p < NPAD; p++) cfg_write(1, p, 3, 32'hFFFF_FFFF);
        cfg_write(2, 0, 6, 32'hFFFF_FFFF);
        cfg_write(2, 0, 7, 32'hFFFF_FFFF);
        for (int i = 0; i < 30; i++) step(1'b1, rnd_rec(), $urandom & $urandom);
        flush();

        // R9: writes blocked while running, accepted afterwards
        do_reset();
        force_tag = 9;
        run_en = 1'b1;
        cfg_write(0, 0, 0, 32'hFFFF_FFFF);
        cfg_write(0, 0, 1, 32'hFFFF_FFFF);
        cfg_write(0, 0, 2, 32'hFFFF_FFFF);
        for (int i = 0; i < 30; i++) step(1'b1, rnd_rec(), $urandom);
        flush();
        run_en = 1'b0;
        cfg_write(0, 0, 0, 32'hFFFF_FFFF);
        for (int i = 0; i < 10; i++) step(1'b1, rnd_rec(), $urandom);
        flush();

        // Random configurations and traffic
        force_tag = 0;
        for (int round = 0; round < 8; round++) begin
            cfg_write(0, 0, 0, $urandom);
            cfg_write(0, 0, 1, $urandom);
            cfg_write(0, 0, 2, $urandom);
            for (int p = 0; p < NPAD; p++) begin
                for (int k = 0; k < 3; k++) cfg_write(1, p, k, $urandom & $urandom);
                for (int k = 0; k < 6; k++) cfg_write(2, p, k, $urandom & $urandom & $urandom);
            end
            for (int i = 0; i < 200; i++)
                step(($urandom % 4) != 0, rnd_rec(), $urandom & $urandom & $urandom);
            flush();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule